// File: doc/BRIEF.md
# PS/2 Keyboard Serial Receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each serial frame into one byte. It runs entirely on the fast system clock. Both lines pass through a two-stage synchroniser. The keyboard clock is then debounced, and its falling edges mark the moments to sample the data line. Each frame holds eleven bits: a start bit that must be 0, eight data bits with the least significant bit first, an odd parity bit, and a stop bit that must be 1.

A frame that passes all checks loads its byte into an output holding register and raises a data-available flag. The flag and the byte stay put until the consumer pulses a one-cycle read acknowledge. One error flag covers three cases: a parity error, a framing error, and an overflow, which is a new good frame arriving while the previous byte has not been read. The error flag also clears on the read acknowledge. A frame that stops partway through is dropped after a timeout with no falling edge, and the receiver goes back to waiting for a start bit.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `code_vld` is 0, `err_o` is 0 and `code_o` is 0x00.
- R2: An 11-bit frame is accepted if its first bit is 0, its last bit is 1, and its bits 2 to 10 hold an odd number of ones. Bits 2 to 9 carry the byte, least significant bit first. An accepted frame loads that byte into `code_o` and sets `code_vld` to 1, provided `code_vld` was 0.
- R3: Once set, `code_vld` stays at 1 and `code_o` keeps its value until `rd_ack` is high for one clock. After that clock, both `code_vld` and `err_o` read 0.
- R4: A frame whose nine data-plus-parity bits hold an even number of ones sets `err_o` to 1. It leaves `code_vld` and `code_o` unchanged.
- R5: A frame whose start bit is 1, or whose stop bit is 0, sets `err_o` to 1. It leaves `code_vld` and `code_o` unchanged.
- R6: An accepted frame that arrives while `code_vld` is 1 sets `err_o` to 1. `code_o` keeps the earlier byte.
- R7: A low pulse on `kb_clk` that lasts fewer than `DEB_CYCLES` system clocks is not taken as an edge. It does not shift the bit position of the next real frame.
- R8: If no falling edge arrives for `TIMEOUT_CYCLES` system clocks while a frame is partly received, the partial frame is dropped without any change at the outputs. The next full frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the keyboard clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_clk | input | 1 | Keyboard clock line, asynchronous to `clk` |
| kb_dat | input | 1 | Keyboard data line, asynchronous to `clk` |
| rd_ack | input | 1 | One-cycle pulse from the consumer that takes the held byte |
| code_o | output | 8 | Last accepted byte |
| code_vld | output | 1 | High while an unread byte is held |
| err_o | output | 1 | Parity, framing or overflow error since the last read |

## Verification
The assertions assume that `rd_ack` is a single-cycle pulse and that it never lands in the same cycle as the internal frame-complete pulse. They also assume that data is stable around each falling edge of the debounced keyboard clock. The stimulus acknowledges only long after a frame has ended. It changes `kb_dat` only while `kb_clk` is high, with half-periods of many system clocks. A behavioural model predicts the three outputs on every clock. It applies frame results only after a settling window, and it applies reads in the exact cycle they take effect.

// File: rtl/ps2rx_pkg.sv
// Package: shared frame layout for the PS/2 receiver.
// Assumes bits arrive oldest-first and are shifted in at the top.
package ps2rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int BYTE_BITS  = 8;

    // Frame as it sits in the shift register once complete (bit 0 = first bit on the wire).
    typedef struct packed {
        logic                 stop_b;
        logic                 par_b;
        logic [BYTE_BITS-1:0] data_b;
        logic                 start_b;
    } frame_t;
endpackage

// File: rtl/ps2rx_sync.sv
// Two-flip-flop synchroniser for a vector of asynchronous inputs.
// Assumes the lines idle high, so the stages reset to 1.
module ps2rx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ps2rx_debounce.sv
// Debounce filter and falling-edge detector for the synchronised keyboard clock.
// The filtered level follows the input only after DEB_CYCLES equal samples in a row.
module ps2rx_debounce #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Count consecutive samples that disagree with the filtered level, then adopt the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
            fall_o <= 1'b0;
        end else begin
            fall_o <= 1'b0;
            if (lvl_i == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                cnt_q  <= '0;
                filt_q <= lvl_i;
                fall_o <= filt_q & ~lvl_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ps2rx_shifter.sv
// Frame assembler: shifts in one bit per falling edge and flags completion after eleven bits.
// Drops a partial frame when no edge arrives within TIMEOUT_CYCLES clocks.
module ps2rx_shifter
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 200000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fall_i,
    input  logic   dat_i,
    output logic   done_o,
    output logic   good_o,
    output frame_t frame_o
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] sh_q;
    logic [BW-1:0]         bit_q;
    logic [TW-1:0]         tmo_q;

    // Shift, count bits and run the inter-edge timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            tmo_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (fall_i) begin
                sh_q  <= {dat_i, sh_q[FRAME_BITS-1:1]};
                tmo_q <= '0;
                if (bit_q == BW'(FRAME_BITS - 1)) begin
                    bit_q  <= '0;
                    done_o <= 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end else if (bit_q != '0) begin
                if (tmo_q == TW'(TIMEOUT_CYCLES - 1)) begin
                    bit_q <= '0;
                    tmo_q <= '0;
                end else begin
                    tmo_q <= tmo_q + 1'b1;
                end
            end
        end
    end

    assign frame_o = frame_t'(sh_q);
    // Frame check: start low, stop high, odd ones over data and parity.
    assign good_o  = ~frame_o.start_b & frame_o.stop_b & (^{frame_o.data_b, frame_o.par_b});
endmodule

// File: rtl/ps2rx_hold.sv
// Output holding register with a data-available / read-acknowledge handshake and a sticky error.
// Assumes rd_ack is a one-cycle pulse; a frame result in the same cycle takes precedence.
module ps2rx_hold
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic                 good_i,
    input  logic [BYTE_BITS-1:0] byte_i,
    input  logic                 rd_ack,
    output logic [BYTE_BITS-1:0] code_o,
    output logic                 code_vld,
    output logic                 err_o
);
    // Capture accepted bytes, flag errors and overflow, clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            code_vld <= 1'b0;
            err_o    <= 1'b0;
        end else if (done_i) begin
            if (!good_i || code_vld) begin
                err_o <= 1'b1;
            end else begin
                code_o   <= byte_i;
                code_vld <= 1'b1;
            end
        end else if (rd_ack) begin
            code_vld <= 1'b0;
            err_o    <= 1'b0;
        end
    end
endmodule

// File: rtl/ps2_frame_rx.sv
// Top of the PS/2 keyboard receiver: synchroniser, clock debounce, frame assembler, holding register.
// Assumes clk is far faster than the keyboard clock (DEB_CYCLES well under a half bit period).
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int DEB_CYCLES     = 16,
    parameter int TIMEOUT_CYCLES = 200000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kb_clk,
    input  logic                 kb_dat,
    input  logic                 rd_ack,
    output logic [BYTE_BITS-1:0] code_o,
    output logic                 code_vld,
    output logic                 err_o
);
    logic [1:0] sync_s;
    logic       fall_s;
    logic       frame_done;
    logic       frame_good;
    frame_t     frame_s;

    ps2rx_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({kb_dat, kb_clk}),
        .q_o   (sync_s)
    );

    ps2rx_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_s[0]),
        .fall_o (fall_s)
    );

    ps2rx_shifter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall_s),
        .dat_i   (sync_s[1]),
        .done_o  (frame_done),
        .good_o  (frame_good),
        .frame_o (frame_s)
    );

    ps2rx_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (frame_done),
        .good_i   (frame_good),
        .byte_i   (frame_s.data_b),
        .rd_ack   (rd_ack),
        .code_o   (code_o),
        .code_vld (code_vld),
        .err_o    (err_o)
    );
endmodule

// File: rtl/ps2_frame_rx_chk.sv
// Checker for the PS/2 receiver handshake; attached to the top module by bind.
// Assumes rd_ack does not coincide with a frame-complete pulse.
module ps2_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_ack,
    input logic [7:0] code_o,
    input logic       code_vld,
    input logic       err_o,
    input logic       done,
    input logic       good
);
    AST_VLD_FROM_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_vld) |-> ($past(done) && $past(good))); // R2
    AST_VLD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && !rd_ack) |=> code_vld); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !done) |=> (!code_vld && !err_o)); // R3
    AST_ERR_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(done)); // R4
    AST_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> $stable(code_o)); // R6
endmodule

bind ps2_frame_rx ps2_frame_rx_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ack   (rd_ack),
    .code_o   (code_o),
    .code_vld (code_vld),
    .err_o    (err_o),
    .done     (frame_done),
    .good     (frame_good)
);

// File: tb/ps2_frame_rx_tb_top.sv
module ps2_frame_rx_tb_top;
    localparam int DEB  = 4;
    localparam int TMO  = 1500;
    localparam int HALF = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_dat = 1'b1;
    logic       rd_ack = 1'b0;
    logic [7:0] code_o;
    logic       code_vld;
    logic       err_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  cmp_en  = 1'b0;
    bit  finished = 1'b0;

    // Behavioural model of the outputs.
    bit         m_vld = 1'b0;
    bit         m_err = 1'b0;
    logic [7:0] m_code = 8'h00;

    always #5 clk = ~clk;

    ps2_frame_rx #(.DEB_CYCLES(DEB), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .kb_clk(kb_clk), .kb_dat(kb_dat),
        .rd_ack(rd_ack), .code_o(code_o), .code_vld(code_vld), .err_o(err_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #3;
        if (cmp_en && rst_n) begin
            if (code_vld !== m_vld || err_o !== m_err || code_o !== m_code) begin
                n_tests++;
                n_fail++;
                $display("FAIL R3 per-clock actual=%b/%b/%h expected=%b/%b/%h",
                         code_vld, err_o, code_o, m_vld, m_err, m_code);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Drive nbits of a frame; a full frame updates the model after settling.
    task automatic send(input logic [7:0] b, input bit bad_par, input bit st, input bit sp, input int nbits);
        logic [10:0] bits;
        bits = {sp, (~^b) ^ bad_par, b, st};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) kb_dat = bits[i];
            wait_clk(HALF);
            if (i == 10) cmp_en = 1'b0;
            @(negedge clk) kb_clk = 1'b0;
            wait_clk(HALF);
            @(negedge clk) kb_clk = 1'b1;
            wait_clk(HALF);
        end
        @(negedge clk) kb_dat = 1'b1;
        if (nbits == 11) begin
            wait_clk(30);
            if (st == 1'b0 && sp == 1'b1 && !bad_par) begin
                if (m_vld) m_err = 1'b1;
                else begin m_vld = 1'b1; m_code = b; end
            end else begin
                m_err = 1'b1;
            end
            @(negedge clk) cmp_en = 1'b1;
        end
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(posedge clk);
        #1;
        m_vld = 1'b0;
        m_err = 1'b0;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_clk(5);
        @(negedge clk) rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        check("R1 vld", code_vld, 0);
        check("R1 err", err_o, 0);
        check("R1 code", code_o, 8'h00);
        cmp_en = 1'b1;

        send(8'h1C, 0, 0, 1, 11);
        @(negedge clk);
        check("R2 vld", code_vld, 1);
        check("R2 code", code_o, 8'h1C);
        wait_clk(500);
        @(negedge clk);
        check("R3 vld held", code_vld, 1);

        send(8'h5A, 0, 0, 1, 11);
        @(negedge clk);
        check("R6 err", err_o, 1);
        check("R6 code kept", code_o, 8'h1C);

        ack();
        @(negedge clk);
        check("R3 vld cleared", code_vld, 0);
        check("R3 err cleared", err_o, 0);

        send(8'h33, 1, 0, 1, 11);
        @(negedge clk);
        check("R4 err", err_o, 1);
        check("R4 vld", code_vld, 0);
        check("R4 code", code_o, 8'h1C);
        ack();

        send(8'h44, 0, 0, 0, 11);
        @(negedge clk);
        check("R5 stop err", err_o, 1);
        check("R5 stop vld", code_vld, 0);
        ack();

        send(8'h66, 0, 1, 1, 11);
        @(negedge clk);
        check("R5 start err", err_o, 1);
        check("R5 start code", code_o, 8'h1C);
        ack();

        // Short glitch on the keyboard clock, data high.
        @(negedge clk) kb_clk = 1'b0;
        wait_clk(DEB - 2);
        @(negedge clk) kb_clk = 1'b1;
        wait_clk(200);
        send(8'hA5, 0, 0, 1, 11);
        @(negedge clk);
        check("R7 code", code_o, 8'hA5);
        check("R7 err", err_o, 0);
        ack();

        // Partial frame, then stall past the timeout.
        send(8'h0F, 0, 0, 1, 5);
        wait_clk(TMO + 300);
        @(negedge clk);
        check("R8 no vld", code_vld, 0);
        check("R8 no err", err_o, 0);
        send(8'h81, 0, 0, 1, 11);
        @(negedge clk);
        check("R8 code", code_o, 8'h81);
        check("R8 err", err_o, 0);
        check("R8 vld", code_vld, 1);
        ack();

        wait_clk(20);
        finish_run();
    end
endmodule